// File: doc/BRIEF.md
# Display Controller Register File

This block is the memory-mapped control register file of a display controller. It sits on a word-oriented 32-bit register bus. It decodes each request offset into a scalar register, into one of three table regions (colour palette, cursor palette, cursor pattern), into an accepted-but-ignored timing register, or into nothing. The pixel path and the frame memory live elsewhere. This block presents the scalar register contents and the cursor palette on its outputs. For the colour palette and the cursor pattern it issues one-cycle write strobes, each carrying an entry index and data.

A request is a single cycle with valid high, a write flag and a 2-bit size code. Byte and halfword writes are merged into the addressed 32-bit word by byte lane: the current word is read, the lanes that are written are replaced, and the result is stored. Narrow reads pick the addressed lanes out of the aligned word. Read data arrives one cycle after the request. The block also derives the pixel depth from a field of the main control register. It drives a frame interrupt line, which the display pipeline raises once per frame and which any register write lowers.

Top module: `dcRegFile`

## Requirements
- R1: After reset every scalar register and every cursor palette entry is 0, irq, errPulse, rdValid and both table strobes are 0, and depthBpp is 1 (the depth of code 0).
- R2: A read request (reqValid=1, reqWrite=0) makes rdValid high with rdData valid in the following cycle only. A write request never produces rdValid.
- R3: The identifier word at offset 0x000000 reads 0x00000010. A write to it is accepted without error and does not change the value read back.
- R4: Full-word writes (reqSize=2, or the reserved code 3) to control A (0x080300), top of screen (0x080400), cursor position (0x080638), display width (0x080118) or display height (0x080150) store the value. A read returns it, and the matching output port shows it after the write cycle.
- R5: A byte write (reqSize=0) takes its data from reqWdata[7:0] and places it at bits [8n+7:8n] of the word, where n = reqAddr[1:0]. The other three bytes keep their values.
- R6: A halfword write (reqSize=1) takes reqWdata[15:0] and writes bits [31:16] when reqAddr[1]=1, or bits [15:0] when reqAddr[1]=0. The other half keeps its value.
- R7: A byte read returns (word >> 8*reqAddr[1:0]) & 0xFF. A halfword read returns bits [31:16] when reqAddr[1]=1, or bits [15:0] otherwise, zero-extended.
- R8: depthBpp follows control A bits [22:20]. Codes 0..7 give 1, 2, 4, 8, 15, 16, 0, 0 (0 means unsupported). blankForce is control A bit 10 and cursorOff is control A bit 23.
- R9: The cursor palette has 3 entries of 24 bits, at 0x080508 + 8*i. An entry stores bits [23:0] of the merged word, reads back as {8'h00, R, G, B}, and is shown on curPalFlat[24i+23:24i].
- R10: A write into the colour palette (0x080800 to 0x080FFF) or the cursor pattern (0x081000 to 0x081FFF) raises that region's strobe for exactly the cycle after the request. The strobe carries index (offset - base) >> 3 and data equal to merged-word bits [23:0] (colour) or [15:0] (pattern). These tables are not held here, so they read 0 and narrow writes merge into 0.
- R11: Writes to the boot register (0x080000) and to the timing registers (0x080108, 0x080110, 0x080120, 0x080128, 0x080130, 0x080138, 0x080140, 0x080148, 0x080158, 0x080160, 0x080168, 0x080170, 0x080200) raise no error and change no output. These offsets read 0.
- R12: A read of any other offset returns 0. A write to it changes nothing and makes errPulse high for exactly one cycle, the cycle after the request.
- R13: irq goes high the cycle after frameTick and is lowered by any write request, whatever the offset. If frameTick and a write come in the same cycle, irq ends up high. Reads do not affect irq.
- R14: Any write to the reset offset 0x180000 clears control A, top of screen, cursor position, display width, display height and the three cursor palette entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request valid for this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| reqAddr | input | 21 | Byte offset into the register space |
| reqWdata | input | 32 | Write data, narrow data in the low bits |
| frameTick | input | 1 | One pulse per frame update |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| errPulse | output | 1 | One-cycle flag for a write to an undefined offset |
| irq | output | 1 | Frame interrupt line |
| ctrlA | output | 32 | Control A register |
| topOfScreen | output | 32 | Top-of-screen offset register |
| cursorPos | output | 32 | Cursor position register |
| dispWidth | output | 32 | Display width register |
| dispHeight | output | 32 | Display height register |
| depthBpp | output | 5 | Bits per pixel derived from control A |
| blankForce | output | 1 | Forced blanking bit of control A |
| cursorOff | output | 1 | Cursor disable bit of control A |
| curPalFlat | output | 72 | Cursor palette entries, entry i at bits [24i+23:24i] |
| colWrEn | output | 1 | Colour palette write strobe |
| colWrIdx | output | 8 | Colour palette entry index |
| colWrData | output | 24 | Colour palette entry data |
| patWrEn | output | 1 | Cursor pattern write strobe |
| patWrIdx | output | 9 | Cursor pattern entry index |
| patWrData | output | 16 | Cursor pattern entry data |

## Verification
The bench sends byte writes to all four lanes and halfword writes to both halves of a register that already holds a known value, then reads back with every size. A design that shifted by the wrong lane, or did not merge and so zeroed the untouched bytes, would return a corrupted word. Table accesses are placed at the first and last entries of each region, at an address with bit 2 set inside an entry, and one word past the end of the cursor palette. An off-by-one range compare or a wrong stride would give a wrong index, a strobe where an error is expected, or an error where a strobe is expected. The interrupt is tested with a read, with a write to an ignored timing offset, and with a frame pulse and a write in the same cycle. A design that cleared irq only on defined registers, or gave the clear priority, would show a wrong level. All eight depth codes and the reset offset are also covered, along with writes to the timing registers and the read-only identifier, which must leave every output untouched and raise no error.

// File: rtl/dcRegPkg.sv
package dcRegPkg;
  localparam int ADDR_W = 21;
  localparam int WORD_W = 32;
  localparam int RGB_W = 24;
  localparam int PAT_W = 16;
  localparam int ENTRY_SHIFT = 3;
  localparam int CPAL_N = 3;

  localparam logic [ADDR_W-1:0] COLPAL_BASE = 21'h080800;
  localparam logic [ADDR_W-1:0] COLPAL_SPAN = 21'h000800;
  localparam logic [ADDR_W-1:0] PAT_BASE = 21'h081000;
  localparam logic [ADDR_W-1:0] PAT_SPAN = 21'h001000;
  localparam logic [ADDR_W-1:0] CPAL_BASE = 21'h080508;
  localparam logic [ADDR_W-1:0] CPAL_SPAN = 21'(CPAL_N << ENTRY_SHIFT);

  localparam int COL_N = int'(COLPAL_SPAN >> ENTRY_SHIFT);
  localparam int PAT_N = int'(PAT_SPAN >> ENTRY_SHIFT);
  localparam int COL_IDX_W = $clog2(COL_N);
  localparam int IDX_W = $clog2(PAT_N);

  localparam logic [ADDR_W-1:0] OFF_ID = 21'h000000;
  localparam logic [ADDR_W-1:0] OFF_CTLA = 21'h080300;
  localparam logic [ADDR_W-1:0] OFF_TOP = 21'h080400;
  localparam logic [ADDR_W-1:0] OFF_CPOS = 21'h080638;
  localparam logic [ADDR_W-1:0] OFF_WIDTH = 21'h080118;
  localparam logic [ADDR_W-1:0] OFF_HEIGHT = 21'h080150;
  localparam logic [ADDR_W-1:0] OFF_SOFTRST = 21'h180000;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTLA, SEL_TOP, SEL_CPOS, SEL_WIDTH, SEL_HEIGHT,
    SEL_CPAL, SEL_COLPAL, SEL_PAT, SEL_IGNORE, SEL_SOFTRST
  } regSel_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    regSel_e sel;
    logic [IDX_W-1:0] idx;
    logic [1:0] lane;
    size_e size;
  } strobe_t;

  // Offsets whose writes are taken but have no effect (boot and timing).
  function automatic logic isQuietOff(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    case (a)
      21'h080200, 21'h080170, 21'h080168, 21'h080160, 21'h080158,
      21'h080148, 21'h080140, 21'h080138, 21'h080130, 21'h080128,
      21'h080120, 21'h080110, 21'h080108, 21'h080000: hit = 1'b1;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic [4:0] bppOfCode(input logic [2:0] code);
    logic [4:0] b;
    case (code)
      3'd0: b = 5'd1;
      3'd1: b = 5'd2;
      3'd2: b = 5'd4;
      3'd3: b = 5'd8;
      3'd4: b = 5'd15;
      3'd5: b = 5'd16;
      default: b = 5'd0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dcRegCtrl.sv
module dcRegCtrl
  import dcRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              frameTick,
  output strobe_t           stb,
  output logic              errPulse,
  output logic              irq
);
  logic [ADDR_W-1:0] wordAddr;
  regSel_e sel;
  logic [IDX_W-1:0] idx;
  logic wrReq;

  assign wordAddr = {reqAddr[ADDR_W-1:2], 2'b00};
  assign wrReq = reqValid && reqWrite;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (wordAddr >= COLPAL_BASE && wordAddr < COLPAL_BASE + COLPAL_SPAN) begin
      sel = SEL_COLPAL;
      idx = IDX_W'((wordAddr - COLPAL_BASE) >> ENTRY_SHIFT);
    end else if (wordAddr >= PAT_BASE && wordAddr < PAT_BASE + PAT_SPAN) begin
      sel = SEL_PAT;
      idx = IDX_W'((wordAddr - PAT_BASE) >> ENTRY_SHIFT);
    end else if (wordAddr >= CPAL_BASE && wordAddr < CPAL_BASE + CPAL_SPAN) begin
      sel = SEL_CPAL;
      idx = IDX_W'((wordAddr - CPAL_BASE) >> ENTRY_SHIFT);
    end else if (isQuietOff(wordAddr)) begin
      sel = SEL_IGNORE;
    end else begin
      case (wordAddr)
        OFF_ID:      sel = SEL_ID;
        OFF_CTLA:    sel = SEL_CTLA;
        OFF_TOP:     sel = SEL_TOP;
        OFF_CPOS:    sel = SEL_CPOS;
        OFF_WIDTH:   sel = SEL_WIDTH;
        OFF_HEIGHT:  sel = SEL_HEIGHT;
        OFF_SOFTRST: sel = SEL_SOFTRST;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb.wrEn = wrReq;
    stb.rdEn = reqValid && !reqWrite;
    stb.sel  = sel;
    stb.idx  = idx;
    stb.lane = reqAddr[1:0];
    stb.size = size_e'(reqSize);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      irq <= 1'b0;
    end else begin
      errPulse <= wrReq && (sel == SEL_NONE);
      if (frameTick) irq <= 1'b1;
      else if (wrReq) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dcRegData.sv
module dcRegData
  import dcRegPkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h0000_0010
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [WORD_W-1:0]       reqWdata,
  output logic                    rdValid,
  output logic [WORD_W-1:0]       rdData,
  output logic [WORD_W-1:0]       ctrlA,
  output logic [WORD_W-1:0]       topOfScreen,
  output logic [WORD_W-1:0]       cursorPos,
  output logic [WORD_W-1:0]       dispWidth,
  output logic [WORD_W-1:0]       dispHeight,
  output logic [4:0]              depthBpp,
  output logic                    blankForce,
  output logic                    cursorOff,
  output logic [CPAL_N*RGB_W-1:0] curPalFlat,
  output logic                    colWrEn,
  output logic [COL_IDX_W-1:0]    colWrIdx,
  output logic [RGB_W-1:0]        colWrData,
  output logic                    patWrEn,
  output logic [IDX_W-1:0]        patWrIdx,
  output logic [PAT_W-1:0]        patWrData
);
  logic [CPAL_N-1:0][RGB_W-1:0] cpalVec;
  logic [RGB_W-1:0] cpalRd;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] narrowRd;
  logic softRst;

  assign softRst = stb.wrEn && (stb.sel == SEL_SOFTRST);

  always_comb begin
    cpalRd = '0;
    for (int e = 0; e < CPAL_N; e++)
      if (stb.idx == IDX_W'(e)) cpalRd = cpalVec[e];
  end

  // Current content of the addressed word; tables held elsewhere read 0.
  always_comb begin
    case (stb.sel)
      SEL_ID:     curWord = ID_VALUE;
      SEL_CTLA:   curWord = ctrlA;
      SEL_TOP:    curWord = topOfScreen;
      SEL_CPOS:   curWord = cursorPos;
      SEL_WIDTH:  curWord = dispWidth;
      SEL_HEIGHT: curWord = dispHeight;
      SEL_CPAL:   curWord = {{(WORD_W-RGB_W){1'b0}}, cpalRd};
      default:    curWord = '0;
    endcase
  end

  // Lane merge for narrow writes.
  always_comb begin
    merged = curWord;
    case (stb.size)
      SZ_BYTE: merged[8*stb.lane +: 8] = reqWdata[7:0];
      SZ_HALF: merged[16*stb.lane[1] +: 16] = reqWdata[15:0];
      default: merged = reqWdata;
    endcase
  end

  // Lane extract for narrow reads.
  always_comb begin
    case (stb.size)
      SZ_BYTE: narrowRd = {{(WORD_W-8){1'b0}}, curWord[8*stb.lane +: 8]};
      SZ_HALF: narrowRd = {{(WORD_W-16){1'b0}}, curWord[16*stb.lane[1] +: 16]};
      default: narrowRd = curWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= narrowRd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA <= '0;
      topOfScreen <= '0;
      cursorPos <= '0;
      dispWidth <= '0;
      dispHeight <= '0;
    end else if (softRst) begin
      ctrlA <= '0;
      topOfScreen <= '0;
      cursorPos <= '0;
      dispWidth <= '0;
      dispHeight <= '0;
    end else if (stb.wrEn) begin
      case (stb.sel)
        SEL_CTLA:   ctrlA <= merged;
        SEL_TOP:    topOfScreen <= merged;
        SEL_CPOS:   cursorPos <= merged;
        SEL_WIDTH:  dispWidth <= merged;
        SEL_HEIGHT: dispHeight <= merged;
        default:    ;
      endcase
    end
  end

  for (genvar e = 0; e < CPAL_N; e++) begin : g_cpal
    logic [RGB_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entry <= '0;
      else if (softRst) entry <= '0;
      else if (stb.wrEn && stb.sel == SEL_CPAL && stb.idx == IDX_W'(e))
        entry <= merged[RGB_W-1:0];
    end
    assign cpalVec[e] = entry;
    assign curPalFlat[e*RGB_W +: RGB_W] = entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colWrEn <= 1'b0;
      colWrIdx <= '0;
      colWrData <= '0;
      patWrEn <= 1'b0;
      patWrIdx <= '0;
      patWrData <= '0;
    end else begin
      colWrEn <= stb.wrEn && stb.sel == SEL_COLPAL;
      patWrEn <= stb.wrEn && stb.sel == SEL_PAT;
      if (stb.wrEn && stb.sel == SEL_COLPAL) begin
        colWrIdx <= stb.idx[COL_IDX_W-1:0];
        colWrData <= merged[RGB_W-1:0];
      end
      if (stb.wrEn && stb.sel == SEL_PAT) begin
        patWrIdx <= stb.idx;
        patWrData <= merged[PAT_W-1:0];
      end
    end
  end

  assign depthBpp = bppOfCode(ctrlA[22:20]);
  assign blankForce = ctrlA[10];
  assign cursorOff = ctrlA[23];
endmodule

// File: rtl/dcRegFile.sv
module dcRegFile
  import dcRegPkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h0000_0010
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]       reqWdata,
  input  logic                    frameTick,
  output logic                    rdValid,
  output logic [WORD_W-1:0]       rdData,
  output logic                    errPulse,
  output logic                    irq,
  output logic [WORD_W-1:0]       ctrlA,
  output logic [WORD_W-1:0]       topOfScreen,
  output logic [WORD_W-1:0]       cursorPos,
  output logic [WORD_W-1:0]       dispWidth,
  output logic [WORD_W-1:0]       dispHeight,
  output logic [4:0]              depthBpp,
  output logic                    blankForce,
  output logic                    cursorOff,
  output logic [CPAL_N*RGB_W-1:0] curPalFlat,
  output logic                    colWrEn,
  output logic [COL_IDX_W-1:0]    colWrIdx,
  output logic [RGB_W-1:0]        colWrData,
  output logic                    patWrEn,
  output logic [IDX_W-1:0]        patWrIdx,
  output logic [PAT_W-1:0]        patWrData
);
  strobe_t stb;

  dcRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .frameTick(frameTick),
    .stb(stb), .errPulse(errPulse), .irq(irq)
  );

  dcRegData #(.ID_VALUE(ID_VALUE)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .ctrlA(ctrlA),
    .topOfScreen(topOfScreen), .cursorPos(cursorPos),
    .dispWidth(dispWidth), .dispHeight(dispHeight), .depthBpp(depthBpp),
    .blankForce(blankForce), .cursorOff(cursorOff), .curPalFlat(curPalFlat),
    .colWrEn(colWrEn), .colWrIdx(colWrIdx), .colWrData(colWrData),
    .patWrEn(patWrEn), .patWrIdx(patWrIdx), .patWrData(patWrData)
  );
endmodule

// File: rtl/dcRegChecker.sv
module dcRegChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqWrite,
  input logic       frameTick,
  input logic       rdValid,
  input logic       errPulse,
  input logic       irq,
  input logic [4:0] depthBpp,
  input logic       colWrEn,
  input logic       patWrEn
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid); // R2
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid); // R2
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> irq); // R13
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !frameTick) |=> !irq); // R13
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && !(reqValid && reqWrite)) |=> $stable(irq)); // R13
  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(reqValid && reqWrite)); // R12
  AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    depthBpp inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16}); // R8
  AST_TABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({colWrEn, patWrEn, errPulse})); // R10
  AST_TABLE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (colWrEn || patWrEn) |-> $past(reqValid && reqWrite)); // R10
endmodule

bind dcRegFile dcRegChecker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .frameTick(frameTick), .rdValid(rdValid), .errPulse(errPulse), .irq(irq),
  .depthBpp(depthBpp), .colWrEn(colWrEn), .patWrEn(patWrEn)
);

// File: tb/sim_dcRegFile.sv
`timescale 1ns/1ps
module sim_dcRegFile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, frameTick = 1'b0;
  logic [1:0] reqSize = 2'd2;
  logic [20:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rdValid, errPulse, irq, blankForce, cursorOff, colWrEn, patWrEn;
  logic [31:0] rdData, ctrlA, topOfScreen, cursorPos, dispWidth, dispHeight;
  logic [4:0] depthBpp;
  logic [71:0] curPalFlat;
  logic [7:0] colWrIdx;
  logic [23:0] colWrData;
  logic [8:0] patWrIdx;
  logic [15:0] patWrData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  dcRegFile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic w, input logic [1:0] sz, input logic [20:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqSize = sz; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [20:0] a, input logic [31:0] d);
    busOp(1'b1, sz, a, d);
    chk("R2 no read data after write", {31'd0, rdValid}, 32'd0);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [20:0] a, input logic [31:0] exp,
                    input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busOp(1'b0, sz, a, 32'h0);
  endtask

  // Monitor: pops the scoreboard whenever read data appears.
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk("R2 unexpected rdValid", 32'd1, 32'd0);
      else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, rdData, e);
      end
    end
  end

  function automatic logic [4:0] refBpp(input int code);
    case (code)
      0: return 5'd1;
      1: return 5'd2;
      2: return 5'd4;
      3: return 5'd8;
      4: return 5'd15;
      5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrlA", ctrlA, 0);
    chk("R1 topOfScreen", topOfScreen, 0);
    chk("R1 dispWidth", dispWidth, 0);
    chk("R1 curPalFlat low", curPalFlat[31:0], 0);
    chk("R1 irq/err/rdValid/strobes", {27'd0, irq, errPulse, rdValid, colWrEn, patWrEn}, 0);
    chk("R1 depthBpp", {27'd0, depthBpp}, 32'd1);

    // R3 identifier
    rd(2'd2, 21'h000000, 32'h10, "R3 id read");
    wr(2'd2, 21'h000000, 32'hFFFF_FFFF);
    chk("R3 id write no error", {31'd0, errPulse}, 0);
    rd(2'd2, 21'h000000, 32'h10, "R3 id after write");

    // R4 full word registers
    wr(2'd2, 21'h080300, 32'h1234_5678);
    chk("R4 ctrlA port", ctrlA, 32'h1234_5678);
    wr(2'd2, 21'h080400, 32'hCAFE_F00D);
    wr(2'd3, 21'h080638, 32'h00AB_C123);
    wr(2'd2, 21'h080118, 32'd640);
    wr(2'd2, 21'h080150, 32'd480);
    chk("R4 cursorPos port (size 3)", cursorPos, 32'h00AB_C123);
    chk("R4 dispHeight port", dispHeight, 32'd480);
    rd(2'd2, 21'h080300, 32'h1234_5678, "R4 ctrlA read");
    rd(2'd2, 21'h080400, 32'hCAFE_F00D, "R4 top read");
    rd(2'd2, 21'h080638, 32'h00AB_C123, "R4 cursorPos read");
    rd(2'd2, 21'h080118, 32'd640, "R4 width read");

    // R5 byte lane merge
    wr(2'd0, 21'h080302, 32'hFFFF_FFAA);
    chk("R5 lane2", ctrlA, 32'h12AA_5678);
    wr(2'd0, 21'h080300, 32'h0000_0011);
    chk("R5 lane0", ctrlA, 32'h12AA_5611);
    wr(2'd0, 21'h080303, 32'h0000_009F);
    chk("R5 lane3", ctrlA, 32'h9FAA_5611);
    wr(2'd0, 21'h080401, 32'h0000_005A);
    chk("R5 lane1", topOfScreen, 32'hCAFE_5A0D);

    // R6 halfword merge
    wr(2'd1, 21'h080402, 32'hFFFF_1234);
    chk("R6 upper half", topOfScreen, 32'h1234_5A0D);
    wr(2'd1, 21'h080400, 32'h0000_BEEF);
    chk("R6 lower half", topOfScreen, 32'h1234_BEEF);

    // R7 narrow reads
    rd(2'd0, 21'h080401, 32'hBE, "R7 byte lane1");
    rd(2'd0, 21'h080403, 32'h12, "R7 byte lane3");
    rd(2'd0, 21'h080400, 32'hEF, "R7 byte lane0");
    rd(2'd1, 21'h080402, 32'h1234, "R7 half upper");
    rd(2'd1, 21'h080400, 32'hBEEF, "R7 half lower");

    // R8 depth codes and control bits
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 21'h080300, 32'(c) << 20);
      chk($sformatf("R8 depth code %0d", c), {27'd0, depthBpp}, {27'd0, refBpp(c)});
    end
    wr(2'd2, 21'h080300, 32'h0080_0400);
    chk("R8 blank/cursorOff", {30'd0, blankForce, cursorOff}, 32'd3);
    chk("R8 depth code 0 again", {27'd0, depthBpp}, 32'd1);

    // R9 cursor palette
    wr(2'd2, 21'h080508, 32'hFF11_2233);
    wr(2'd2, 21'h080510, 32'h0044_5566);
    wr(2'd2, 21'h080518, 32'h0077_8899);
    rd(2'd2, 21'h080508, 32'h0011_2233, "R9 entry0 packed");
    wr(2'd0, 21'h080511, 32'h0000_00AB);
    rd(2'd2, 21'h080510, 32'h0044_AB66, "R9 entry1 byte merge");
    chk("R9 flat entry2", {8'd0, curPalFlat[71:48]}, 32'h0077_8899);
    chk("R9 flat entry1", {8'd0, curPalFlat[47:24]}, 32'h0044_AB66);

    // R10 table strobes
    wr(2'd2, 21'h080828, 32'h00FE_DCBA);
    chk("R10 col strobe", {31'd0, colWrEn}, 1);
    chk("R10 col idx", {24'd0, colWrIdx}, 5);
    chk("R10 col data", {8'd0, colWrData}, 32'h00FE_DCBA);
    @(negedge clk);
    chk("R10 col strobe one cycle", {31'd0, colWrEn}, 0);
    wr(2'd2, 21'h080FF8, 32'h0000_0001);
    chk("R10 col last idx", {24'd0, colWrIdx}, 255);
    wr(2'd0, 21'h080801, 32'h0000_0077);
    chk("R10 col byte merge into 0", {8'd0, colWrData}, 32'h0000_7700);
    rd(2'd2, 21'h080800, 32'h0, "R10 col reads 0");
    wr(2'd2, 21'h081960, 32'hFFFF_1357);
    chk("R10 pat strobe", {31'd0, patWrEn}, 1);
    chk("R10 pat idx/data", {7'd0, patWrIdx, patWrData}, {7'd0, 9'd300, 16'h1357});
    wr(2'd2, 21'h081FF8, 32'h0);
    chk("R10 pat last idx", {23'd0, patWrIdx}, 511);
    wr(2'd2, 21'h08100C, 32'h0);
    chk("R10 pat bit2 idx", {23'd0, patWrIdx}, 1);

    // R11 quiet offsets
    wr(2'd2, 21'h080300, 32'h0030_0000);
    wr(2'd2, 21'h080108, 32'hFFFF_FFFF);
    chk("R11 timing no error", {31'd0, errPulse}, 0);
    wr(2'd0, 21'h080000, 32'hFF);
    chk("R11 boot no error", {31'd0, errPulse}, 0);
    chk("R11 ctrlA untouched", ctrlA, 32'h0030_0000);
    rd(2'd2, 21'h080108, 32'h0, "R11 timing reads 0");

    // R12 undefined offsets
    wr(2'd2, 21'h080304, 32'hFFFF_FFFF);
    chk("R12 err pulse", {31'd0, errPulse}, 1);
    @(negedge clk);
    chk("R12 err one cycle", {31'd0, errPulse}, 0);
    chk("R12 ctrlA untouched", ctrlA, 32'h0030_0000);
    wr(2'd2, 21'h080520, 32'h1);
    chk("R12 past cursor palette", {31'd0, errPulse}, 1);
    rd(2'd2, 21'h080304, 32'h0, "R12 undefined reads 0");

    // R13 interrupt
    @(negedge clk); frameTick = 1'b1;
    @(negedge clk); frameTick = 1'b0;
    chk("R13 irq set", {31'd0, irq}, 1);
    rd(2'd2, 21'h000000, 32'h10, "R13 id read");
    chk("R13 read keeps irq", {31'd0, irq}, 1);
    wr(2'd2, 21'h080110, 32'h0);
    chk("R13 write clears irq", {31'd0, irq}, 0);
    @(negedge clk);
    frameTick = 1'b1; reqValid = 1'b1; reqWrite = 1'b1; reqSize = 2'd2;
    reqAddr = 21'h080400; reqWdata = 32'h55;
    @(negedge clk);
    frameTick = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    chk("R13 set wins over clear", {31'd0, irq}, 1);

    // R14 reset offset
    wr(2'd0, 21'h180000, 32'h0);
    chk("R14 ctrlA cleared", ctrlA, 0);
    chk("R14 top cleared", topOfScreen, 0);
    chk("R14 width cleared", dispWidth, 0);
    chk("R14 cursor palette cleared", {8'd0, curPalFlat[23:0]}, 0);
    rd(2'd2, 21'h080518, 32'h0, "R14 palette entry2 reads 0");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", expQ.size(), 0);
    finish();
  end
endmodule